// File: doc/BRIEF.md
# External Edge Interrupt Line Controller

This block turns pins from several GPIO ports into sixteen edge-triggered interrupt requests. Every interrupt line has an index, and the pin with that same index on each port is a candidate source for it. A per-line port-select field picks one of those candidates, so for a given pin number only one port can raise interrupts at a time. The chosen pin passes through a two-flop synchroniser. A rising edge, a falling edge, or both are then detected, depending on two trigger-select registers.

A detected edge sets a sticky pending flag. The flag stays set until software writes a one to its bit in the pending register. A mask register gates each pending flag onto its interrupt request output. A flag still latches while its line is masked, so unmasking the line later raises the request. All configuration goes through a small word-addressed register bus with a one-cycle write strobe and a combinational read port.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every configuration register and every pending flag is zero, and every interrupt request output is low.
- R2: Line i takes its source from the select field at register address i/4, bits (i%4)*4+3 down to (i%4)*4. Code p selects pin i of port p, where port p occupies bits p*16+15 down to p*16 of `port_pins`. Edges on the same pin number of any other port have no effect on line i.
- R3: A select code of 7 or above picks no port, so the line can never detect an edge.
- R4: When the rising-trigger bit (address 5) of a line is 1, a low-to-high change on its selected pin sets the pending flag at the third rising clock edge after the change, and not earlier.
- R5: When the falling-trigger bit (address 6) of a line is 1, a high-to-low change sets the pending flag with the same latency. With both bits set, either direction sets it.
- R6: An edge in a direction whose trigger bit is 0 leaves the pending flag clear. This includes the case where both trigger bits are 0.
- R7: A pending flag latches whether or not the line is masked. The flags read back at address 7. The request `irq[i]` is 1 exactly when the pending flag and the mask bit (address 4) of line i are both 1.
- R8: A pending flag stays set until a write to address 7 with a 1 in its bit. Writing 0 to a bit leaves that flag unchanged.
- R9: If an edge is detected in the same cycle as a write-one clear of the same line, the flag stays set.
- R10: Addresses 0 to 6 read back the last value written to their low 16 bits, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_pins | input | 112 | Pins of seven 16-pin ports; port p at bits p*16+15..p*16 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| irq | output | 16 | Interrupt request per line |

## Verification
An edge that sets a pending flag and a software write-one clear of that same flag can land on the same clock edge. The bench provokes this by leaving line 0 already pending, raising its pin, and then asserting the clear write exactly two clock edges after the pin change, when the synchronised edge is about to be captured. The flag must still read 1 afterwards. A later clear on its own must bring it to 0.

// File: rtl/extint_pkg.sv
package extint_pkg;
    localparam int LINES    = 16;
    localparam int PORTS    = 7;
    localparam int SEL_W    = 4;
    localparam int FIELDS   = 4;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int SEL_REGS = LINES / FIELDS;
    localparam int A_MASK   = SEL_REGS;
    localparam int A_RISE   = SEL_REGS + 1;
    localparam int A_FALL   = SEL_REGS + 2;
    localparam int A_PEND   = SEL_REGS + 3;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic pend;
    } line_st_t;

    typedef struct packed {
        logic [SEL_REGS-1:0][FIELDS*SEL_W-1:0] sel;
        logic [LINES-1:0]                      mask;
        logic [LINES-1:0]                      rise;
        logic [LINES-1:0]                      fall;
    } cfg_t;
endpackage

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    input  logic [LINES-1:0]        pend_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic [LINES*SEL_W-1:0]  sel_o,
    output logic [LINES-1:0]        mask_o,
    output logic [LINES-1:0]        rise_o,
    output logic [LINES-1:0]        fall_o,
    output logic [LINES-1:0]        clr_o
);
    localparam int REG_W = FIELDS * SEL_W;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            for (int k = 0; k < SEL_REGS; k++) begin
                if (addr_i == ADDR_W'(k)) cfg_d.sel[k] = wdata_i[REG_W-1:0];
            end
            if (addr_i == ADDR_W'(A_MASK)) cfg_d.mask = wdata_i[LINES-1:0];
            if (addr_i == ADDR_W'(A_RISE)) cfg_d.rise = wdata_i[LINES-1:0];
            if (addr_i == ADDR_W'(A_FALL)) cfg_d.fall = wdata_i[LINES-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < SEL_REGS; k++) begin
            if (addr_i == ADDR_W'(k)) rdata_o = DATA_W'(cfg_q.sel[k]);
        end
        if (addr_i == ADDR_W'(A_MASK)) rdata_o = DATA_W'(cfg_q.mask);
        if (addr_i == ADDR_W'(A_RISE)) rdata_o = DATA_W'(cfg_q.rise);
        if (addr_i == ADDR_W'(A_FALL)) rdata_o = DATA_W'(cfg_q.fall);
        if (addr_i == ADDR_W'(A_PEND)) rdata_o = DATA_W'(pend_i);
    end

    assign sel_o  = cfg_q.sel;
    assign mask_o = cfg_q.mask;
    assign rise_o = cfg_q.rise;
    assign fall_o = cfg_q.fall;
    assign clr_o  = (wr_i && addr_i == ADDR_W'(A_PEND)) ? wdata_i[LINES-1:0] : '0;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(cfg_q)); // R10
endmodule

// File: rtl/extint_line.sv
module extint_line
    import extint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PORTS-1:0] pins_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             rise_en_i,
    input  logic             fall_en_i,
    input  logic             clr_i,
    output logic             pend_o
);
    line_st_t st_d, st_q;
    logic     src;
    logic     rise_hit;
    logic     fall_hit;
    logic     edge_hit;

    always_comb begin
        src = 1'b0;
        for (int p = 0; p < PORTS; p++) begin
            if (sel_i == SEL_W'(p)) src = pins_i[p];
        end
        rise_hit  = st_q.s2 & ~st_q.prev & rise_en_i;
        fall_hit  = ~st_q.s2 & st_q.prev & fall_en_i;
        edge_hit  = rise_hit | fall_hit;
        st_d      = st_q;
        st_d.s1   = src;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        st_d.pend = edge_hit | (st_q.pend & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !clr_i) |=> st_q.pend); // R8
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && clr_i && !edge_hit) |=> !st_q.pend); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && clr_i) |=> st_q.pend); // R9
    AST_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_en_i && !fall_en_i && !st_q.pend) |=> !st_q.pend); // R6
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PORTS*LINES-1:0] port_pins,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic [LINES-1:0]       irq
);
    logic [LINES*SEL_W-1:0]       sel;
    logic [LINES-1:0]             mask, rise, fall, clr, pend;
    logic [LINES-1:0][PORTS-1:0]  line_pins;

    extint_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .pend_i  (pend),
        .rdata_o (bus_rdata),
        .sel_o   (sel),
        .mask_o  (mask),
        .rise_o  (rise),
        .fall_o  (fall),
        .clr_o   (clr)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        for (genvar p = 0; p < PORTS; p++) begin : g_pin
            assign line_pins[i][p] = port_pins[p*LINES + i];
        end
        extint_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .pins_i    (line_pins[i]),
            .sel_i     (sel[i*SEL_W +: SEL_W]),
            .rise_en_i (rise[i]),
            .fall_en_i (fall[i]),
            .clr_i     (clr[i]),
            .pend_o    (pend[i])
        );
    end

    assign irq = pend & mask;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~mask) == '0); // R7
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~pend) == '0); // R7
endmodule

// File: tb/sim_extint_ctrl.sv
module sim_extint_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    // {line[3:0], sel[3:0], toggled port[2:0], rise, fall, dir, expected}
    localparam logic [14:0] VEC [NV] = '{
        {4'd0,  4'd0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1},
        {4'd5,  4'd2, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1},
        {4'd9,  4'd6, 3'd6, 1'b1, 1'b1, 1'b1, 1'b1},
        {4'd9,  4'd6, 3'd6, 1'b1, 1'b1, 1'b0, 1'b1},
        {4'd3,  4'd1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'd15, 4'd3, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'd12, 4'd7, 3'd6, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'd7,  4'd4, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd14, 4'd5, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'd10, 4'd2, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    logic         clk = 0;
    logic         rst_n = 0;
    logic [111:0] port_pins = '0;
    logic         bus_wr = 0;
    logic [2:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [15:0]  irq;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extint_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .port_pins(port_pins), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reg", v, 0);
        end
        // R10 readback
        wr(3'd2, 32'hFFFF6543);
        rd(3'd2, v); chk("R10 sel", v, 32'h6543);
        wr(3'd6, 32'h0000A5C3);
        rd(3'd6, v); chk("R10 fall", v, 32'hA5C3);
        wr(3'd2, 0); wr(3'd6, 0);
        wr(3'd4, 32'hFFFF);

        // table walk: R2 R3 R4 R5 R6
        for (int n = 0; n < NV; n++) begin
            logic [3:0] ln, sl; logic [2:0] tg; logic rs, fl, dr, ex;
            {ln, sl, tg, rs, fl, dr, ex} = VEC[n];
            wr(3'd5, 0); wr(3'd6, 0);
            wr(3'(ln / 4), 32'(sl) << ((ln % 4) * 4));
            @(negedge clk);
            port_pins = dr ? '0 : '1;
            repeat (5) @(negedge clk);
            wr(3'd7, 32'hFFFF);
            wr(3'd5, 32'(rs) << ln);
            wr(3'd6, 32'(fl) << ln);
            port_pins[tg*16 + ln] = dr;
            repeat (2) @(posedge clk);
            @(negedge clk);
            chk($sformatf("R4 latency vec %0d", n), 32'(irq), 0);
            @(posedge clk); @(negedge clk);
            chk($sformatf("R2 R3 R4 R5 R6 irq vec %0d", n), 32'(irq), 32'(ex) << ln);
            rd(3'd7, v);
            chk($sformatf("R2 R3 R4 R5 R6 pend vec %0d", n), v, 32'(ex) << ln);
        end

        // reset config for directed tests: line 0 on port 0, rising only
        wr(3'd5, 0); wr(3'd6, 0); wr(3'd0, 0);
        @(negedge clk); port_pins = '0;
        repeat (5) @(negedge clk);
        wr(3'd7, 32'hFFFF);
        wr(3'd5, 32'h1);

        // R7 latch while masked
        wr(3'd4, 0);
        port_pins[0] = 1;
        repeat (4) @(negedge clk);
        chk("R7 masked irq", 32'(irq), 0);
        rd(3'd7, v); chk("R7 masked pend", v, 1);
        wr(3'd4, 32'hFFFF);
        @(negedge clk);
        chk("R7 unmasked irq", 32'(irq), 1);

        // R8 write zero ignored
        wr(3'd7, 32'hFFFE);
        @(negedge clk);
        chk("R8 zero-write irq", 32'(irq), 1);

        // R9 set beats clear in same cycle
        port_pins[0] = 0;
        repeat (5) @(negedge clk);
        chk("R8 still pend", 32'(irq), 1);
        port_pins[0] = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_wr = 1; bus_addr = 3'd7; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 0;
        rd(3'd7, v); chk("R9 set wins", v, 1);

        // R8 clear alone
        wr(3'd7, 32'h1);
        @(negedge clk);
        chk("R8 clear irq", 32'(irq), 0);
        rd(3'd7, v); chk("R8 clear pend", v, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule